// File: doc/BRIEF.md
# Adaptive DRAM Row Closure Controller

This block sits beside a DRAM command scheduler and tracks which row is open in each of the sixteen banks of a two-rank, eight-bank-per-rank memory. After each completed column access, and on every later cycle while the row stays open, it decides whether the row should be precharged. When it decides to close a row it raises a one-cycle precharge request for that bank. The scheduler reports each completed access as a rank, bank and row. It also gives, for every bank, a two-bit summary of its pending queue: whether some queued request hits the open row, and whether some queued request targets a different row.

The closure rule comes from a policy register that can be rewritten at run time, but only while no bank holds an open row. Four of the policies are fixed rules: keep the row open, close after every access, and two queue-driven adaptive rules. The fifth policy is predictive. Each bank keeps a short history of recently closed rows and the number of hits each of them collected. A row that opens again is held until it has served the same number of hits. A row with no history stays open until a conflicting access displaces it. DRAM timing and command ordering are left to the scheduler.

Top module: `rcc_row_closure_ctrl`

## Requirements
- R1: After reset, every bank reads closed, no precharge request is raised, and the policy reads 0 (keep open).
- R2: Policy codes are 0 keep-open, 1 close-always, 2 open-adaptive, 3 close-adaptive and 4 predictive. A write is accepted only when `bank_open_o` is all zero and the code is at most 4, and the new value shows on `policy_o` one cycle later. Otherwise the write is ignored.
- R3: The flat bank index is rank*8+bank. An access to a closed bank opens its row, and this shows on `bank_open_o` and `open_row_o` (bank b at bits b*14 upward) one cycle later. An access to the open row counts as a hit. An access to a different row replaces the open row without any precharge request.
- R4: A precharge request lasts exactly one cycle. It appears one cycle after the cycle in which the closure condition held, and the bank reads closed in that same cycle. An access to the bank in the evaluation cycle suppresses closure for that cycle.
- R5: Under keep-open, no precharge request is ever raised.
- R6: Under close-always, an open bank that receives no access is precharged in the next cycle, so a pulse follows every access run.
- R7: Under open-adaptive, an open bank is precharged only when its pending-hit flag is low and its other-row flag is high.
- R8: Under close-adaptive, an open bank is precharged whenever its pending-hit flag is low.
- R9: Under predictive, a row that has a history entry is precharged once the number of hits since its activation reaches the stored count. A stored count of 0 closes the row right after activation.
- R10: Under predictive, a row with no history entry is never precharged and stays open until a conflicting access.
- R11: On every closure, whether by precharge or by conflict and under any policy, the bank's history records the row and its hit count, saturated at 15. The history holds 4 rows ordered by closure recency. An entry that already holds the row is refreshed, and otherwise the least recently closed row is evicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_we_i | input | 1 | Policy write strobe |
| pol_wdata_i | input | 3 | Policy code to write |
| acc_valid_i | input | 1 | A column access completed this cycle |
| acc_rank_i | input | 1 | Rank of the access |
| acc_bank_i | input | 3 | Bank within the rank |
| acc_row_i | input | 14 | Row of the access |
| pend_hit_i | input | 16 | Per bank: a queued request hits the open row |
| pend_other_i | input | 16 | Per bank: a queued request targets another row |
| pre_req_o | output | 16 | Per bank one-cycle precharge request |
| bank_open_o | output | 16 | Per bank row-open flag |
| open_row_o | output | 224 | Per bank open row, 14 bits each |
| policy_o | output | 3 | Current policy code |

## Verification
A corrupted open-row record or hit counter shows up in the cycle after the access that follows it: the wrong row appears on `open_row_o`, or a precharge pulse arrives one cycle early or late. A fault in the history order or in the saturation stays hidden until that row opens again under the predictive policy. It then shows as a missing pulse, an extra pulse or a shifted pulse, so the stimulus reopens rows after evictions and after long hit runs. Policy gating faults show as soon as a write is attempted while a bank is open.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    typedef enum logic [2:0] {
        POL_OPEN        = 3'd0,
        POL_CLOSE       = 3'd1,
        POL_OPEN_ADAPT  = 3'd2,
        POL_CLOSE_ADAPT = 3'd3,
        POL_PREDICT     = 3'd4
    } policy_e;

    localparam logic [2:0] POL_LAST = 3'd4;
endpackage

// File: rtl/rcc_hist_table.sv
module rcc_hist_table #(
    parameter int ROW_W = 14,
    parameter int HIT_W = 4,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] look_row_i,
    input  logic             upd_en_i,
    input  logic [ROW_W-1:0] upd_row_i,
    input  logic [HIT_W-1:0] upd_hits_i,
    output logic             look_hit_o,
    output logic [HIT_W-1:0] look_cnt_o
);
    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
        logic [HIT_W-1:0] cnt;
    } ent_t;

    ent_t [DEPTH-1:0] tab_d, tab_q;

    // lookup: position 0 is the most recently closed row
    always_comb begin
        look_hit_o = 1'b0;
        look_cnt_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (tab_q[i].vld && tab_q[i].row == look_row_i) begin
                look_hit_o = 1'b1;
                look_cnt_o = tab_q[i].cnt;
            end
        end
    end

    // update: move the written row to the front, shift the rows ahead of it down
    always_comb begin
        int stop;
        tab_d = tab_q;
        stop  = DEPTH - 1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (tab_q[i].vld && tab_q[i].row == upd_row_i) stop = i;
        end
        if (upd_en_i) begin
            for (int i = 1; i < DEPTH; i++) begin
                if (i <= stop) tab_d[i] = tab_q[i-1];
            end
            tab_d[0].vld = 1'b1;
            tab_d[0].row = upd_row_i;
            tab_d[0].cnt = upd_hits_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end
endmodule

// File: rtl/rcc_close_decide.sv
module rcc_close_decide #(
    parameter int HIT_W = 4
) (
    input  rcc_pkg::policy_e policy_i,
    input  logic             open_i,
    input  logic             busy_i,
    input  logic [HIT_W-1:0] hits_i,
    input  logic             pred_vld_i,
    input  logic [HIT_W-1:0] pred_cnt_i,
    input  logic             pend_hit_i,
    input  logic             pend_other_i,
    output logic             close_o
);
    import rcc_pkg::*;

    logic rule;

    always_comb begin
        case (policy_i)
            POL_CLOSE:       rule = 1'b1;
            POL_OPEN_ADAPT:  rule = !pend_hit_i && pend_other_i;
            POL_CLOSE_ADAPT: rule = !pend_hit_i;
            POL_PREDICT:     rule = pred_vld_i && (hits_i >= pred_cnt_i);
            default:         rule = 1'b0;
        endcase
        close_o = open_i && !busy_i && rule;
    end
endmodule

// File: rtl/rcc_row_closure_ctrl.sv
module rcc_row_closure_ctrl #(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int ROW_W          = 14,
    parameter int HIT_W          = 4,
    parameter int HIST_DEPTH     = 4,
    localparam int NUM_BANKS     = NUM_RANKS * BANKS_PER_RANK,
    localparam int RANK_W        = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W        = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pol_we_i,
    input  logic [2:0]                 pol_wdata_i,
    input  logic                       acc_valid_i,
    input  logic [RANK_W-1:0]          acc_rank_i,
    input  logic [BANK_W-1:0]          acc_bank_i,
    input  logic [ROW_W-1:0]           acc_row_i,
    input  logic [NUM_BANKS-1:0]       pend_hit_i,
    input  logic [NUM_BANKS-1:0]       pend_other_i,
    output logic [NUM_BANKS-1:0]       pre_req_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
    output logic [2:0]                 policy_o
);
    import rcc_pkg::*;

    localparam logic [HIT_W-1:0] HIT_MAX = '1;

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [HIT_W-1:0] hits;
        logic             pv;
        logic [HIT_W-1:0] pred;
    } bank_t;

    typedef struct packed {
        policy_e                 pol;
        logic [NUM_BANKS-1:0]    pre;
        bank_t [NUM_BANKS-1:0]   bank;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_BANKS-1:0] acc_here;
    logic [NUM_BANKS-1:0] close_w;
    logic [NUM_BANKS-1:0] look_hit;
    logic [HIT_W-1:0]     look_cnt [NUM_BANKS];
    logic [NUM_BANKS-1:0] upd_en;

    always_comb begin
        int idx;
        idx = int'(acc_rank_i) * BANKS_PER_RANK + int'(acc_bank_i);
        for (int b = 0; b < NUM_BANKS; b++) begin
            acc_here[b] = acc_valid_i && (idx == b);
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rcc_close_decide #(.HIT_W(HIT_W)) u_decide (
            .policy_i     (state_q.pol),
            .open_i       (state_q.bank[b].open),
            .busy_i       (acc_here[b]),
            .hits_i       (state_q.bank[b].hits),
            .pred_vld_i   (state_q.bank[b].pv),
            .pred_cnt_i   (state_q.bank[b].pred),
            .pend_hit_i   (pend_hit_i[b]),
            .pend_other_i (pend_other_i[b]),
            .close_o      (close_w[b])
        );

        rcc_hist_table #(.ROW_W(ROW_W), .HIT_W(HIT_W), .DEPTH(HIST_DEPTH)) u_hist (
            .clk        (clk),
            .rst_n      (rst_n),
            .look_row_i (acc_row_i),
            .upd_en_i   (upd_en[b]),
            .upd_row_i  (state_q.bank[b].row),
            .upd_hits_i (state_q.bank[b].hits),
            .look_hit_o (look_hit[b]),
            .look_cnt_o (look_cnt[b])
        );

        assign open_row_o[b*ROW_W +: ROW_W] = state_q.bank[b].row;
        assign bank_open_o[b]               = state_q.bank[b].open;
    end

    always_comb begin
        state_d     = state_q;
        state_d.pre = '0;
        upd_en      = '0;

        for (int b = 0; b < NUM_BANKS; b++) begin
            if (acc_here[b]) begin
                if (state_q.bank[b].open && state_q.bank[b].row == acc_row_i) begin
                    if (state_q.bank[b].hits != HIT_MAX)
                        state_d.bank[b].hits = state_q.bank[b].hits + 1'b1;
                end else begin
                    // a conflicting access retires the old row into the history
                    upd_en[b]            = state_q.bank[b].open;
                    state_d.bank[b].open = 1'b1;
                    state_d.bank[b].row  = acc_row_i;
                    state_d.bank[b].hits = '0;
                    state_d.bank[b].pv   = look_hit[b];
                    state_d.bank[b].pred = look_cnt[b];
                end
            end else if (close_w[b]) begin
                upd_en[b]            = 1'b1;
                state_d.bank[b].open = 1'b0;
                state_d.pre[b]       = 1'b1;
            end
        end

        if (pol_we_i && (bank_open_o == '0) && (pol_wdata_i <= POL_LAST))
            state_d.pol = policy_e'(pol_wdata_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pre_req_o = state_q.pre;
    assign policy_o  = state_q.pol;
endmodule

// File: rtl/rcc_row_closure_chk.sv
module rcc_row_closure_chk #(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int ROW_W          = 14,
    parameter int HIT_W          = 4,
    parameter int HIST_DEPTH     = 4,
    localparam int NUM_BANKS     = NUM_RANKS * BANKS_PER_RANK,
    localparam int RANK_W        = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W        = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       pol_we_i,
    input logic [2:0]                 pol_wdata_i,
    input logic                       acc_valid_i,
    input logic [RANK_W-1:0]          acc_rank_i,
    input logic [BANK_W-1:0]          acc_bank_i,
    input logic [ROW_W-1:0]           acc_row_i,
    input logic [NUM_BANKS-1:0]       pend_hit_i,
    input logic [NUM_BANKS-1:0]       pend_other_i,
    input logic [NUM_BANKS-1:0]       pre_req_o,
    input logic [NUM_BANKS-1:0]       bank_open_o,
    input logic [NUM_BANKS*ROW_W-1:0] open_row_o,
    input logic [2:0]                 policy_o
);
    logic [NUM_BANKS-1:0] hit_bank;
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++)
            hit_bank[b] = acc_valid_i &&
                (int'(acc_rank_i) * BANKS_PER_RANK + int'(acc_bank_i) == b);
    end

    assert_pre_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_req_o & $past(pre_req_o)) == '0);

    assert_pre_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_req_o & (bank_open_o | ~$past(bank_open_o))) == '0);

    assert_policy_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_open_o) |=> $stable(policy_o));

    assert_policy_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        policy_o <= 3'd4);

    assert_open_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_o == 3'd0) |=> (pre_req_o == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        assert_close_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (policy_o == 3'd1 && bank_open_o[b] && !hit_bank[b]) |=> pre_req_o[b]);

        assert_oa_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (policy_o == 3'd2 && (pend_hit_i[b] || !pend_other_i[b])) |=> !pre_req_o[b]);

        assert_ca_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (policy_o == 3'd3 && pend_hit_i[b]) |=> !pre_req_o[b]);

        assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            hit_bank[b] |=> !pre_req_o[b]);
    end
endmodule

bind rcc_row_closure_ctrl rcc_row_closure_chk #(
    .NUM_RANKS(NUM_RANKS), .BANKS_PER_RANK(BANKS_PER_RANK), .ROW_W(ROW_W),
    .HIT_W(HIT_W), .HIST_DEPTH(HIST_DEPTH)
) u_chk (.*);

// File: tb/rcc_row_closure_ctrl_tb.sv
module rcc_row_closure_ctrl_tb;
    localparam int NB = 16;
    localparam int RW = 14;
    localparam int HD = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n;
    logic           pol_we;
    logic [2:0]     pol_wdata;
    logic           acc_valid;
    logic [0:0]     acc_rank;
    logic [2:0]     acc_bank;
    logic [RW-1:0]  acc_row;
    logic [NB-1:0]  pend_hit, pend_other;
    logic [NB-1:0]  pre_req, bank_open;
    logic [NB*RW-1:0] open_row;
    logic [2:0]     policy;

    rcc_row_closure_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pol_we_i(pol_we), .pol_wdata_i(pol_wdata),
        .acc_valid_i(acc_valid), .acc_rank_i(acc_rank), .acc_bank_i(acc_bank),
        .acc_row_i(acc_row), .pend_hit_i(pend_hit), .pend_other_i(pend_other),
        .pre_req_o(pre_req), .bank_open_o(bank_open), .open_row_o(open_row),
        .policy_o(policy)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state built from the requirements
    bit            m_open [NB];
    logic [RW-1:0] m_row  [NB];
    int            m_hits [NB];
    bit            m_pv   [NB];
    int            m_pred [NB];
    bit            m_pre  [NB];
    int            m_pol;
    bit            t_v [NB][HD];
    logic [RW-1:0] t_r [NB][HD];
    int            t_c [NB][HD];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string pol_req(int p);
        case (p)
            1: return "R6";
            2: return "R7";
            3: return "R8";
            4: return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 0; m_row[b] = '0; m_hits[b] = 0; m_pv[b] = 0;
            m_pred[b] = 0; m_pre[b] = 0;
            for (int i = 0; i < HD; i++) begin t_v[b][i] = 0; t_r[b][i] = '0; t_c[b][i] = 0; end
        end
        m_pol = 0;
    endtask

    task automatic tab_put(int b, logic [RW-1:0] row, int cnt);
        int stop = HD - 1;
        for (int i = HD - 1; i >= 0; i--) if (t_v[b][i] && t_r[b][i] == row) stop = i;
        for (int i = HD - 1; i >= 1; i--) begin
            if (i <= stop) begin t_v[b][i] = t_v[b][i-1]; t_r[b][i] = t_r[b][i-1]; t_c[b][i] = t_c[b][i-1]; end
        end
        t_v[b][0] = 1; t_r[b][0] = row; t_c[b][0] = cnt;
    endtask

    function automatic bit rule(int b);
        case (m_pol)
            1: return 1;
            2: return !pend_hit[b] && pend_other[b];
            3: return !pend_hit[b];
            4: return m_pv[b] && (m_hits[b] >= m_pred[b]);
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        int  idx = int'(acc_rank) * 8 + int'(acc_bank);
        bit  all_closed = 1;
        for (int b = 0; b < NB; b++) if (m_open[b]) all_closed = 0;
        for (int b = 0; b < NB; b++) begin
            bit acc = acc_valid && (idx == b);
            m_pre[b] = 0;
            if (acc) begin
                if (m_open[b] && m_row[b] == acc_row) begin
                    if (m_hits[b] < 15) m_hits[b]++;
                end else begin
                    bit fh = 0; int fc = 0;
                    for (int i = HD - 1; i >= 0; i--)
                        if (t_v[b][i] && t_r[b][i] == acc_row) begin fh = 1; fc = t_c[b][i]; end
                    if (m_open[b]) tab_put(b, m_row[b], m_hits[b]);
                    m_open[b] = 1; m_row[b] = acc_row; m_hits[b] = 0; m_pv[b] = fh; m_pred[b] = fc;
                end
            end else if (m_open[b] && rule(b)) begin
                tab_put(b, m_row[b], m_hits[b]);
                m_open[b] = 0; m_pre[b] = 1;
            end
        end
        if (pol_we && all_closed && pol_wdata <= 3'd4) m_pol = int'(pol_wdata);
    endtask

    task automatic compare();
        for (int b = 0; b < NB; b++) begin
            check(pre_req[b] == m_pre[b], pol_req(m_pol), $sformatf("pre bank %0d", b), pre_req[b], m_pre[b]);
            check(bank_open[b] == m_open[b], "R3", $sformatf("open bank %0d", b), bank_open[b], m_open[b]);
            if (m_open[b])
                check(open_row[b*RW +: RW] == m_row[b], "R3", $sformatf("row bank %0d", b),
                      open_row[b*RW +: RW], m_row[b]);
        end
        check(int'(policy) == m_pol, "R2", "policy", policy, m_pol);
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic clear_in();
        pol_we = 0; pol_wdata = '0; acc_valid = 0; acc_rank = '0; acc_bank = '0;
        acc_row = '0; pend_hit = '0; pend_other = '0;
    endtask

    task automatic do_reset();
        rst_n = 0; clear_in(); model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic acc(int rk, int bk, int row);
        acc_valid = 1; acc_rank = 1'(rk); acc_bank = 3'(bk); acc_row = RW'(row);
        cyc();
        acc_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic setpol(int p);
        pol_we = 1; pol_wdata = 3'(p);
        cyc();
        pol_we = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(bank_open == '0, "R1", "open after reset", bank_open, 0);
        check(pre_req == '0, "R1", "pre after reset", pre_req, 0);
        check(policy == 3'd0, "R1", "policy after reset", policy, 0);

        // R2 reserved code, legal code, write blocked while open
        setpol(6);
        check(policy == 3'd0, "R2", "reserved code ignored", policy, 0);
        setpol(3);
        check(policy == 3'd3, "R2", "write accepted", policy, 3);
        pend_hit[1] = 1;
        acc(0, 1, 5);
        setpol(0);
        check(policy == 3'd3, "R2", "write while open ignored", policy, 3);
        // R8 release pending hit
        pend_hit[1] = 0;
        cyc();
        check(pre_req[1] == 1'b1, "R8", "close-adaptive pulse", pre_req[1], 1);
        check(bank_open[1] == 1'b0, "R4", "closed with pulse", bank_open[1], 0);

        // R6 and R4 under close-always
        setpol(1);
        acc(1, 2, 7);
        check(bank_open[10] == 1'b1, "R3", "rank1 bank2 is index 10", bank_open[10], 1);
        acc(1, 2, 7);
        check(pre_req[10] == 1'b0, "R4", "access suppresses closure", pre_req[10], 0);
        idle(1);
        check(pre_req[10] == 1'b1, "R6", "pulse after access", pre_req[10], 1);
        idle(1);
        check(pre_req[10] == 1'b0, "R4", "pulse is one cycle", pre_req[10], 0);

        // predictive directed cases
        do_reset();
        setpol(4);
        acc(0, 3, 10); acc(0, 3, 10); acc(0, 3, 10);
        idle(5);
        check(bank_open[3] == 1'b1, "R10", "no history stays open", bank_open[3], 1);
        acc(0, 3, 20);
        idle(3);
        check(bank_open[3] == 1'b1, "R10", "new row stays open", bank_open[3], 1);
        acc(0, 3, 10);
        idle(1);
        check(pre_req[3] == 1'b0, "R9", "no early close", pre_req[3], 0);
        acc(0, 3, 10);
        idle(1);
        check(pre_req[3] == 1'b0, "R9", "one hit of two", pre_req[3], 0);
        acc(0, 3, 10);
        idle(1);
        check(pre_req[3] == 1'b1, "R9", "closes at stored count", pre_req[3], 1);
        acc(0, 3, 20);
        idle(1);
        check(pre_req[3] == 1'b1, "R9", "zero count closes at once", pre_req[3], 1);
        // R11 saturation
        for (int i = 0; i < 20; i++) acc(0, 3, 30);
        acc(0, 3, 40);
        acc(0, 3, 30);
        for (int i = 0; i < 14; i++) acc(0, 3, 30);
        idle(1);
        check(pre_req[3] == 1'b0, "R11", "14 of saturated 15", pre_req[3], 0);
        acc(0, 3, 30);
        idle(1);
        check(pre_req[3] == 1'b1, "R11", "saturated count 15", pre_req[3], 1);
        // R11 eviction order
        for (int r = 50; r <= 54; r++) begin acc(0, 4, r); acc(0, 4, r); end
        acc(0, 4, 55);
        acc(0, 4, 50);
        idle(3);
        check(bank_open[4] == 1'b1, "R11", "evicted row has no entry", bank_open[4], 1);
        acc(0, 4, 52);
        acc(0, 4, 52);
        idle(1);
        check(pre_req[4] == 1'b1, "R11", "retained row predicted", pre_req[4], 1);

        // random phases per policy
        for (int p = 0; p < 5; p++) begin
            do_reset();
            setpol(p);
            for (int n = 0; n < 2500; n++) begin
                acc_valid = ($urandom_range(0, 1) == 1);
                acc_rank  = 1'($urandom_range(0, 1));
                acc_bank  = 3'($urandom_range(0, 3));
                acc_row   = RW'($urandom_range(0, 5));
                pend_hit  = NB'($urandom);
                pend_other = NB'($urandom);
                pol_we    = ($urandom_range(0, 49) == 0);
                pol_wdata = 3'($urandom_range(0, 7));
                cyc();
            end
            clear_in();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule